// File: doc/BRIEF.md
# Serial Control Register Slave

This block is the register end of a four-wire serial control port. A host frames each access with an active-low select and clocks in an 8-bit command and then an 8-bit word address, all most-significant bit first on a serial clock it owns. A write command is followed by sixteen data bits shifted in. A read command is followed by sixteen data bits shifted out of the addressed register. The block holds sixteen 16-bit control words, and the rest of the chip reads them through a flat parallel bus.

The serial lines are brought into the system clock domain through two-stage synchronizers. Clock edges are then detected as level changes between samples, so the serial clock must run well below the system clock. A data-request output drops low for a fixed number of system cycles when each completed access ends, and then returns high. The serial data output is enabled only while read data is being shifted out.

Top module: `scr_slave`

## Requirements
- R1: After reset, word 0 holds 0x4800, word 1 holds 0x000C and words 2 to 15 hold 0x0000. The data-request output is high and the serial output enable is low.
- R2: A frame with command 0x02, then an address below 0x10, then 16 data bits writes those bits to the addressed word. Every field goes MSB first and is sampled on the rising serial clock.
- R3: A frame with command 0x03 and an address below 0x10 drives the addressed word MSB first on the serial output, which changes on falling serial clock edges. The first bit appears on the falling edge after the last address bit. The output enable is high only during that data phase of a read, and is low once select is high.
- R4: During the data phase of a read, the serial input has no effect on the bits returned or on any word.
- R5: A frame whose first eight bits are neither 0x02 nor 0x03 changes no word and produces no data-request pulse, whatever follows before select rises.
- R6: An address with any of bits 7 to 4 set reads back as 0x0000, and a write to it changes no word. Only address bits 3 to 0 choose among the sixteen words.
- R7: A word changes only when the sixteenth data bit of a write frame is received. Raising select before that bit leaves every word unchanged.
- R8: The data-request output goes low for exactly 4 system clock cycles after the last data bit of each completed write or read frame, and is high at all other times.
- R9: Raising select returns the framing to the start of a command, so the next frame decodes correctly after an aborted or ignored one.
- R10: The parallel output carries word i in bits [16*i+15 : 16*i] at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csn_i | input | 1 | Active-low frame select from host |
| sclk_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data into the slave |
| sdo_o | output | 1 | Serial read data out of the slave |
| sdo_oe_o | output | 1 | Enable for the serial output driver |
| dreq_o | output | 1 | Data-request handshake, low while an access completes |
| regs_o | output | 256 | All sixteen words side by side, word 0 in the low bits |

## Verification
The assertions take for granted that each serial clock level lasts at least three system cycles. They also take for granted that select changes only while the serial clock is low and stays settled for several system cycles around each edge. Without those conditions the sampled edge detection can miss or merge edges, and the data-request and commit relations would not hold. The stimulus keeps every serial half-period at eight system cycles and moves select and data only during the low phase. It covers write, read, aborted, ignored and out-of-range frames, with the serial input toggled throughout read data phases.

// File: rtl/scr_pkg.sv
package scr_pkg;

  localparam logic [7:0] CMD_WRITE = 8'h02;
  localparam logic [7:0] CMD_READ  = 8'h03;

  typedef enum logic [2:0] {
    F_CMD,
    F_ADDR,
    F_WDATA,
    F_RDATA,
    F_SKIP
  } frame_st_e;

  // Power-up contents of each control word
  function automatic logic [31:0] word_reset_value(input int unsigned idx);
    case (idx)
      0:       return 32'h0000_4800;
      1:       return 32'h0000_000C;
      default: return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] st_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st_q[g] <= RST_VAL;
          else        st_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st_q[g] <= RST_VAL;
          else        st_q[g] <= st_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = st_q[STAGES-1];

endmodule

// File: rtl/scr_frame.sv
module scr_frame
  import scr_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CMD_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn,
  input  logic              sclk,
  input  logic              sdi,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              done_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);

  localparam int unsigned CW = $clog2(DATA_W + 1);

  frame_st_e         st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [DATA_W-1:0] in_q, in_d, in_nxt;
  logic [DATA_W-1:0] out_q, out_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              rd_q, rd_d;
  logic              sdo_q, sdo_d;
  logic              sclk_q;
  logic              rise, fall;

  assign rise   = sclk & ~sclk_q;
  assign fall   = ~sclk & sclk_q;
  assign in_nxt = {in_q[DATA_W-2:0], sdi};

  assign rd_addr_o = in_nxt[ADDR_W-1:0];
  assign wr_addr_o = addr_q;
  assign wr_data_o = in_nxt;
  assign sdo_o     = sdo_q;
  assign sdo_oe_o  = (st_q == F_RDATA);

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    in_d     = in_q;
    out_d    = out_q;
    addr_d   = addr_q;
    rd_d     = rd_q;
    sdo_d    = sdo_q;
    wr_req_o = 1'b0;
    done_o   = 1'b0;
    if (csn) begin
      st_d  = F_CMD;
      cnt_d = '0;
    end else begin
      case (st_q)
        F_CMD: if (rise) begin
          in_d = in_nxt;
          if (cnt_q == CW'(CMD_W - 1)) begin
            cnt_d = '0;
            if (in_nxt[CMD_W-1:0] == CMD_W'(CMD_WRITE)) begin
              st_d = F_ADDR;
              rd_d = 1'b0;
            end else if (in_nxt[CMD_W-1:0] == CMD_W'(CMD_READ)) begin
              st_d = F_ADDR;
              rd_d = 1'b1;
            end else begin
              st_d = F_SKIP;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        F_ADDR: if (rise) begin
          in_d = in_nxt;
          if (cnt_q == CW'(ADDR_W - 1)) begin
            cnt_d  = '0;
            addr_d = in_nxt[ADDR_W-1:0];
            if (rd_q) begin
              st_d  = F_RDATA;
              out_d = rd_data_i;
              sdo_d = 1'b0;
            end else begin
              st_d = F_WDATA;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        F_WDATA: if (rise) begin
          in_d = in_nxt;
          if (cnt_q == CW'(DATA_W - 1)) begin
            wr_req_o = 1'b1;
            done_o   = 1'b1;
            st_d     = F_SKIP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        F_RDATA: if (fall && (cnt_q < CW'(DATA_W))) begin
          sdo_d = out_q[DATA_W-1];
          out_d = {out_q[DATA_W-2:0], 1'b0};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CW'(DATA_W - 1)) done_o = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= F_CMD;
      cnt_q  <= '0;
      in_q   <= '0;
      out_q  <= '0;
      addr_q <= '0;
      rd_q   <= 1'b0;
      sdo_q  <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      in_q   <= in_d;
      out_q  <= out_d;
      addr_q <= addr_d;
      rd_q   <= rd_d;
      sdo_q  <= sdo_d;
      sclk_q <= sclk;
    end
  end

endmodule

// File: rtl/scr_bank.sv
module scr_bank
  import scr_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_req_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [DATA_W-1:0]          rd_data_o,
  output logic [NUM_REGS-1:0]        we_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);

  localparam int unsigned IDX_W = $clog2(NUM_REGS);

  logic [DATA_W-1:0] word_q [NUM_REGS];
  logic              wr_in_range, rd_in_range;

  assign wr_in_range = (wr_addr_i[ADDR_W-1:IDX_W] == '0);
  assign rd_in_range = (rd_addr_i[ADDR_W-1:IDX_W] == '0);

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
      assign we_o[i] = wr_req_i && wr_in_range &&
                       (wr_addr_i[IDX_W-1:0] == IDX_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       word_q[i] <= DATA_W'(word_reset_value(i));
        else if (we_o[i]) word_q[i] <= wr_data_i;
      end
      assign regs_o[i*DATA_W +: DATA_W] = word_q[i];
    end
  endgenerate

  assign rd_data_o = rd_in_range ? word_q[rd_addr_i[IDX_W-1:0]] : '0;

endmodule

// File: rtl/scr_dreq.sv
module scr_dreq #(
  parameter int unsigned LOW_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic dreq_o
);

  localparam int unsigned CW = $clog2(LOW_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)             cnt_d = CW'(LOW_CYCLES);
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign dreq_o = (cnt_q == '0);

endmodule

// File: rtl/scr_slave.sv
module scr_slave #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned NUM_REGS    = 16,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned CMD_W       = 8,
  parameter int unsigned DREQ_CYCLES = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       csn_i,
  input  logic                       sclk_i,
  input  logic                       sdi_i,
  output logic                       sdo_o,
  output logic                       sdo_oe_o,
  output logic                       dreq_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);

  logic              rst_n_sync;
  logic [1:0]        rst_q;
  logic [2:0]        pins_s;
  logic              csn_s, sclk_s, sdi_s;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_req, done;
  logic [NUM_REGS-1:0] we_vec;

  // Reset asserts at once and is released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_sync = rst_q[1];

  scr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n_sync),
    .d_i  ({csn_i, sclk_i, sdi_i}),
    .q_o  (pins_s)
  );
  assign {csn_s, sclk_s, sdi_s} = pins_s;

  scr_frame #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .csn      (csn_s),
    .sclk     (sclk_s),
    .sdi      (sdi_s),
    .rd_addr_o(rd_addr),
    .rd_data_i(rd_data),
    .wr_req_o (wr_req),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data),
    .done_o   (done),
    .sdo_o    (sdo_o),
    .sdo_oe_o (sdo_oe_o)
  );

  scr_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .wr_req_i (wr_req),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data),
    .we_o     (we_vec),
    .regs_o   (regs_o)
  );

  scr_dreq #(.LOW_CYCLES(DREQ_CYCLES)) u_dreq (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .start_i(done),
    .dreq_o (dreq_o)
  );

endmodule

// File: rtl/scr_slave_chk.sv
module scr_slave_chk #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned NUM_REGS    = 16,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DREQ_CYCLES = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       csn_s,
  input logic                       sdo_oe,
  input logic                       dreq,
  input logic                       done,
  input logic                       wr_req,
  input logic [ADDR_W-1:0]          wr_addr,
  input logic [NUM_REGS-1:0]        we_vec,
  input logic [NUM_REGS*DATA_W-1:0] regs
);

  localparam int unsigned IDX_W = $clog2(NUM_REGS);

  int unsigned low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     low_run <= 0;
    else if (!dreq) low_run <= low_run + 1;
    else            low_run <= 0;
  end

  // R8: a falling request always follows a completed access
  p_dreq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dreq) |-> $past(done));

  // R8: the request never stays low longer than the set interval
  p_dreq_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= DREQ_CYCLES);

  // R3: output drive only inside a selected frame
  p_oe_framed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> !$past(csn_s));

  // R2: at most one word is targeted by a commit
  p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_vec));

  // R6: out-of-range writes leave the bank as it was
  p_high_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && (wr_addr[ADDR_W-1:IDX_W] != '0)) |=> $stable(regs));

  // R7: words move only on a completed write
  p_commit_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs) |-> $past(wr_req));

endmodule

bind scr_slave scr_slave_chk #(
  .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DREQ_CYCLES(DREQ_CYCLES)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n_sync),
  .csn_s  (csn_s),
  .sdo_oe (sdo_oe_o),
  .dreq   (dreq_o),
  .done   (done),
  .wr_req (wr_req),
  .wr_addr(wr_addr),
  .we_vec (we_vec),
  .regs   (regs_o)
);

// File: tb/tb_scr_slave.sv
module tb_scr_slave;

  localparam int HALF = 8;     // system cycles per serial clock level
  localparam int LAT  = 3;     // sync stages plus engine register

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         csn = 1'b1;
  logic         sclk = 1'b0;
  logic         sdi = 1'b0;
  logic         sdo, sdo_oe, dreq;
  logic [255:0] regs;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;

  int mem [16];
  bit pend_v = 1'b0;
  int pend_due, pend_addr, pend_data;
  int dreq_from = -100;

  scr_slave dut (
    .clk(clk), .rst_n(rst_n), .csn_i(csn), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .dreq_o(dreq), .regs_o(regs)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Reference model compared on every clock
  always @(negedge clk) begin
    if (mon_on) begin
      if (pend_v && cyc >= pend_due) begin
        if (pend_addr < 16) mem[pend_addr] = pend_data;
        pend_v = 1'b0;
      end
      for (int i = 0; i < 16; i++)
        check($sformatf("R10 word %0d", i), {16'h0, regs[i*16 +: 16]}, mem[i]);
      check("R8 dreq", {31'h0, dreq},
            {31'h0, !(cyc >= dreq_from && cyc < dreq_from + 4)});
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One serial bit; optional read-data sample before the rise
  task automatic bit_xfer(input logic b, input bit commit_at_rise,
                          input bit dreq_at_fall, input bit do_sample,
                          input logic exp_bit, input string tag);
    sdi = b;
    tick(HALF);
    if (do_sample) begin
      check({tag, " oe"}, {31'h0, sdo_oe}, 32'h1);
      check(tag, {31'h0, sdo}, {31'h0, exp_bit});
    end
    sclk = 1'b1;
    if (commit_at_rise) begin
      pend_v = 1'b1;
      pend_due = cyc + LAT;
      dreq_from = cyc + LAT;
    end
    tick(HALF);
    sclk = 1'b0;
    if (dreq_at_fall) dreq_from = cyc + LAT;
  endtask

  task automatic end_frame();
    tick(HALF);
    csn = 1'b1;
    tick(3 * HALF);
    check("R3 oe idle", {31'h0, sdo_oe}, 32'h0);
  endtask

  // Write-shaped frame; data_bits < 16 aborts early
  task automatic wr_frame(input logic [7:0] cmd, input logic [7:0] addr,
                          input logic [15:0] data, input int data_bits);
    csn = 1'b0;
    tick(HALF);
    for (int i = 7; i >= 0; i--) bit_xfer(cmd[i], 0, 0, 0, 1'b0, "");
    for (int i = 7; i >= 0; i--) bit_xfer(addr[i], 0, 0, 0, 1'b0, "");
    if (cmd == 8'h02 && data_bits == 16) begin
      pend_addr = addr;
      pend_data = data;
    end
    for (int k = 0; k < data_bits; k++)
      bit_xfer(data[15-k], (cmd == 8'h02 && k == 15), 0, 0, 1'b0, "");
    end_frame();
  endtask

  task automatic rd_frame(input logic [7:0] addr, input logic [15:0] junk, input string tag);
    logic [15:0] exp;
    exp = (addr < 16) ? 16'(mem[addr]) : 16'h0;
    csn = 1'b0;
    tick(HALF);
    for (int i = 7; i >= 0; i--) bit_xfer(logic'((8'h03 >> i) & 1), 0, 0, 0, 1'b0, "");
    for (int i = 7; i >= 0; i--) bit_xfer(addr[i], 0, 0, 0, 1'b0, "");
    for (int k = 0; k < 16; k++)
      bit_xfer(junk[15-k], 0, (k == 14), 1, exp[15-k], tag);
    end_frame();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 0;
    mem[0] = 'h4800;
    mem[1] = 'h000C;
    tick(5);
    rst_n = 1'b1;
    tick(6);
    mon_on = 1'b1;
    tick(2);
    // R1: reset state at the ports
    check("R1 word0", {16'h0, regs[15:0]}, 32'h4800);
    check("R1 word1", {16'h0, regs[31:16]}, 32'h000C);
    check("R1 dreq", {31'h0, dreq}, 32'h1);
    check("R1 oe", {31'h0, sdo_oe}, 32'h0);

    rd_frame(8'h00, 16'h0000, "R3 read reset word0");
    rd_frame(8'h01, 16'hFFFF, "R3 read reset word1");
    wr_frame(8'h02, 8'h05, 16'hA5C3, 16);              // R2
    rd_frame(8'h05, 16'h0000, "R2 readback word5");
    wr_frame(8'h02, 8'h0F, 16'h8001, 16);              // R2 top word, edge bits
    wr_frame(8'h02, 8'h00, 16'h1234, 16);              // R2 overwrite reset value
    rd_frame(8'h0F, 16'h5A5A, "R4 read with toggling input");
    rd_frame(8'h00, 16'hFFFF, "R4 read word0 input high");
    wr_frame(8'h02, 8'h13, 16'hBEEF, 16);              // R6 write out of range
    rd_frame(8'h13, 16'h0000, "R6 out-of-range read");
    rd_frame(8'h03, 16'h0000, "R6 alias word3 untouched");
    wr_frame(8'h02, 8'h04, 16'hFFFF, 10);              // R7 abort
    rd_frame(8'h04, 16'h0000, "R7 aborted word4");
    wr_frame(8'h05, 8'h02, 16'h0203, 16);              // R5 unknown command
    wr_frame(8'hFF, 8'h07, 16'h7777, 16);              // R5 unknown command
    wr_frame(8'h02, 8'h07, 16'h0F0F, 16);              // R9 framing restarts
    rd_frame(8'h07, 16'hAAAA, "R9 frame after ignored one");
    rd_frame(8'h05, 16'h0000, "R5 word5 kept");
    tick(20);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule